// File: doc/BRIEF.md
# Latency-Insensitive Read Port for a Fixed-Latency RAM

This block puts a stallable, queue-like read interface in front of a synchronous RAM whose read data appears a fixed number of cycles after the address is presented. A client hands in read addresses through a valid/ready request channel. The oldest returned word is then visible on a peek port together with a valid flag, and the client removes it with a one-cycle dequeue strobe whenever it is ready to. The client never needs to know the RAM latency. It may hold off its dequeue for as long as it likes, and no returned word is lost.

Inside, a delay line of the request strobe marks the cycle in which each read word leaves the RAM. That word is then written into a small response FIFO. A credit counter sits between the two channels. It counts reads that have been accepted and not yet dequeued, whether they are still inside the RAM or already waiting in the FIFO. Requests are refused once that count reaches the FIFO depth, so every read in flight has a slot reserved for it before it is issued. The RAM is modelled as a preloaded table whose word at each address is fixed by a closed-form pattern.

Top module: `lsm_wrap`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The word returned for address `a` equals the low `DATA_W` bits of `(a * 32'h9E3779B1) ^ 32'h5A5A5A5A`, computed in 32-bit arithmetic.
- R3: `req_ready` is 1 exactly when the number of outstanding reads is below `DEPTH`. A read is outstanding from its accepting edge until the edge at which it is dequeued.
- R4: Responses come out in the order the requests were accepted. None is dropped or duplicated, whatever the dequeue pattern.
- R5: While `rsp_valid` is 1 and `rsp_deq` is 0, both `rsp_valid` and `rsp_data` hold their values into the next cycle.
- R6: A request accepted at edge `e` is presented no earlier than just after edge `e+LAT`. If all older reads have been dequeued by then, `rsp_valid` is 1 for it right after edge `e+LAT`.
- R7: A dequeue strobe while `rsp_valid` is 0 has no effect: the outstanding count, and therefore `req_ready`, is unchanged.
- R8: An accepted request and an effective dequeue on the same edge leave the outstanding count unchanged.
- R9: `rsp_valid` is 1 only while at least one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Client offers a read address |
| req_ready | output | 1 | A read can be accepted this cycle |
| req_addr | input | ADDR_W | Read address |
| rsp_valid | output | 1 | `rsp_data` holds the oldest unconsumed word |
| rsp_data | output | DATA_W | Oldest returned word (peek) |
| rsp_deq | input | 1 | Remove the word shown on `rsp_data` |

## Verification
The bench builds the block with `LAT=3` and `DEPTH=4`. With these values the credit limit sits just one above the RAM latency. The request channel therefore stalls often even under light back-pressure. A dequeue stall fills the FIFO to its last slot while reads are still in the delay line, and the credit count reaches its limit in the same cycle as a dequeue. These are the cases where a request and a dequeue on one edge, or a dequeue on an empty port, would show up as an error in the credit count.

// File: rtl/lsm_pkg.sv
// Shared definitions for the latency-insensitive RAM read port.
// Assumes data words of at most 32 bits.
package lsm_pkg;

    // Content of the preloaded table at a given address.
    function automatic logic [31:0] lsm_table_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A5A5A;
    endfunction

endpackage

// File: rtl/lsm_ram_pipe.sv
// Fixed-latency read model of a preloaded synchronous RAM.
// The word is looked up on the accepting edge and travels through LAT
// registered stages. A read-valid strobe travels alongside it and marks
// the cycle in which the word leaves the RAM.
// Assumes LAT >= 1 and DATA_W <= 32.
module lsm_ram_pipe
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    logic [LAT-1:0]    vld_q;
    logic [DATA_W-1:0] data_q [LAT];
    logic [31:0]       word_full;

    // Table read for the presented address.
    always_comb word_full = lsm_table_word(32'(rd_addr));

    // First stage: capture the strobe and the looked-up word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0]  <= 1'b0;
            data_q[0] <= '0;
        end else begin
            vld_q[0]  <= rd_fire;
            data_q[0] <= word_full[DATA_W-1:0];
        end
    end

    // Remaining stages: shift strobe and word together.
    for (genvar s = 1; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s]  <= 1'b0;
                data_q[s] <= '0;
            end else begin
                vld_q[s]  <= vld_q[s-1];
                data_q[s] <= data_q[s-1];
            end
        end
    end

    assign out_vld  = vld_q[LAT-1];
    assign out_data = data_q[LAT-1];
endmodule

// File: rtl/lsm_credit.sv
// Credit counter for reads that are outstanding: accepted but not yet
// dequeued. Grants a new read only below LIMIT.
// Assumes the caller raises take only while ready is high.
module lsm_credit #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic ready
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_q;

    // Count up on a grant and down on a release; both on one edge cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({take, give})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign ready = (cnt_q < CW'(LIMIT));
endmodule

// File: rtl/lsm_fifo.sv
// Response FIFO with a combinational head (peek) output.
// Assumes push is never raised while full and pop never while empty.
// The credit counter upstream guarantees both. Assumes DEPTH >= 2.
module lsm_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] fill_q;

    // Write the arriving word into its slot.
    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= wdata;
    end

    // Advance the pointers with wrap-around and keep the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q   <= '0;
            rp_q   <= '0;
            fill_q <= '0;
        end else begin
            if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            if (push && !pop)      fill_q <= fill_q + 1'b1;
            else if (pop && !push) fill_q <= fill_q - 1'b1;
        end
    end

    assign rdata = mem[rp_q];
    assign empty = (fill_q == '0);
    assign full  = (fill_q == CW'(DEPTH));
endmodule

// File: rtl/lsm_wrap.sv
// Top of the latency-insensitive read port. A valid/ready request channel
// feeds a fixed-latency RAM model. Returned words land in a FIFO that the
// client peeks and dequeues. A credit counter limits the reads in flight
// plus the words buffered to DEPTH, so the FIFO cannot overflow.
// Assumes DEPTH >= 2 and LAT >= 1. Full rate needs DEPTH > LAT.
module lsm_wrap #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int LAT    = 3,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_deq
);
    logic              req_fire;
    logic              deq_fire;
    logic              ram_vld;
    logic [DATA_W-1:0] ram_data;
    logic              buf_empty;
    logic              buf_full;

    // Handshake qualification: accepted request and effective dequeue.
    always_comb begin
        req_fire = req_valid && req_ready;
        deq_fire = rsp_deq && rsp_valid;
    end

    lsm_credit #(.LIMIT(DEPTH)) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (req_fire),
        .give  (deq_fire),
        .ready (req_ready)
    );

    lsm_ram_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fire  (req_fire),
        .rd_addr  (req_addr),
        .out_vld  (ram_vld),
        .out_data (ram_data)
    );

    lsm_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ram_vld),
        .wdata (ram_data),
        .pop   (deq_fire),
        .rdata (rsp_data),
        .empty (buf_empty),
        .full  (buf_full)
    );

    assign rsp_valid = !buf_empty;
endmodule

// File: rtl/lsm_wrap_chk.sv
// Property checker for lsm_wrap. It keeps its own outstanding count from
// the port handshakes and relates it to the ready and valid outputs.
module lsm_wrap_chk #(
    parameter int DEPTH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic [31:0] rsp_data_w,
    input logic rsp_deq,
    input logic ram_vld,
    input logic buf_full
);
    int shadow_q;

    // Track outstanding reads from port activity only.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= 0;
        else shadow_q <= shadow_q + int'(req_valid && req_ready)
                                  - int'(rsp_valid && rsp_deq);
    end

    p_ready_credit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready == (shadow_q < DEPTH));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_vld |-> !buf_full);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_deq) |=> (rsp_valid && $stable(rsp_data_w)));

    p_idle_deq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid && !(req_valid && req_ready)) |=> $stable(req_ready));

    p_valid_credit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (shadow_q > 0));
endmodule

bind lsm_wrap lsm_wrap_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data_w (32'(rsp_data)),
    .rsp_deq    (rsp_deq),
    .ram_vld    (ram_vld),
    .buf_full   (buf_full)
);

// File: tb/sim_lsm_wrap.sv
`timescale 1ns/1ps
module sim_lsm_wrap;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int LAT   = 3;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_deq = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    logic [AW-1:0] q_addr [$];
    int            q_arr  [$];

    always #2 clk = ~clk;

    lsm_wrap #(.ADDR_W(AW), .DATA_W(DW), .LAT(LAT), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_deq(rsp_deq)
    );

    // Expected table word per R2.
    function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
        logic [31:0] t;
        t = (32'(a) * 32'h9E3779B1) ^ 32'h5A5A5A5A;
        return t[DW-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // One cycle: drive at negedge, update the model at posedge, check at next negedge.
    task automatic step(input logic rv, input logic [AW-1:0] ra, input logic dq);
        logic fire, deqe, pv, pd_ok;
        logic [DW-1:0] pd;
        req_valid = rv; req_addr = ra; rsp_deq = dq;
        #0.5;
        fire = rv && req_ready;
        deqe = dq && rsp_valid;
        pv = rsp_valid; pd = rsp_data;
        @(posedge clk);
        cyc++;
        if (deqe) begin
            void'(q_addr.pop_front());
            void'(q_arr.pop_front());
        end
        if (fire) begin
            q_addr.push_back(ra);
            q_arr.push_back(cyc + LAT);
        end
        @(negedge clk);
        chk(req_ready == (q_addr.size() < DEPTH), "R3 ready vs outstanding",
            int'(req_ready), int'(q_addr.size() < DEPTH));
        begin
            bit ev;
            ev = (q_addr.size() > 0) && (q_arr[0] <= cyc);
            chk(rsp_valid == ev, "R6 R9 valid timing", int'(rsp_valid), int'(ev));
            if (rsp_valid && ev)
                chk(rsp_data == exp_word(q_addr[0]), "R4 R2 order and data",
                    int'(rsp_data), int'(exp_word(q_addr[0])));
        end
        if (pv && !dq) begin
            pd_ok = rsp_valid && (rsp_data == pd);
            chk(pd_ok, "R5 hold while stalled", int'(rsp_data), int'(pd));
        end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state held
        chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 after reset",
            int'({req_ready, rsp_valid}), 2);

        // R7: dequeue on an empty port is ignored
        repeat (3) step(1'b0, '0, 1'b1);
        chk(req_ready == 1'b1, "R7 empty deq keeps credit", int'(req_ready), 1);

        // R6: single request into an idle block
        step(1'b1, 6'd5, 1'b0);
        repeat (LAT) step(1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b1);

        // R3/R4/R5: fill with dequeue stalled, credit must run out
        for (int i = 0; i < 10; i++) step(1'b1, AW'(i + 20), 1'b0);
        chk(req_ready == 1'b0, "R3 stall at DEPTH", int'(req_ready), 0);
        chk(q_addr.size() == DEPTH, "R3 accepted count", q_addr.size(), DEPTH);

        // R8: drain to DEPTH-1, then request and dequeue on one edge
        step(1'b0, '0, 1'b1);
        step(1'b1, 6'd63, 1'b1);
        chk(req_ready == 1'b1, "R8 req+deq keeps count", int'(req_ready), 1);
        chk(q_addr.size() == DEPTH - 1, "R8 outstanding", q_addr.size(), DEPTH - 1);
        step(1'b1, 6'd62, 1'b0);
        chk(req_ready == 1'b0, "R8 one more fills", int'(req_ready), 0);
        // R7 with credit exhausted: empty-port cases already covered; drain
        for (int i = 0; i < 12; i++) step(1'b0, '0, 1'b1);

        // Random phase with back-pressure
        for (int i = 0; i < 4000; i++) begin
            int mode;
            mode = i / 1000;
            step(($urandom % 10) < (mode == 2 ? 9 : 6), AW'($urandom),
                 ($urandom % 10) < (mode == 1 ? 2 : (mode == 3 ? 9 : 5)));
        end
        // Drain and confirm no loss (R4)
        for (int i = 0; i < 40; i++) step(1'b0, '0, 1'b1);
        chk(q_addr.size() == 0 && !rsp_valid, "R4 all responses delivered",
            q_addr.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule